// File: doc/BRIEF.md
# Data-Buffer Segment Frame Parser

This block watches the receive side of an 8b/10b timing link. Every clock it gets a 16-bit word. The upper byte carries the data-buffer lane and the lower byte carries the event lane, and each byte has its own K-character flag. The block ignores the event lane. On the data lane it looks for segment frames. A frame opens with a start K-character, followed by a fixed header that includes an 8-bit segment number. After the header, payload bytes arrive on every second cycle until an end K-character closes the frame.

Each payload byte leaves the block with an 11-bit byte address and a one-clock valid strobe. The address is the segment number times sixteen plus the byte's offset inside the frame, truncated to 11 bits. A downstream buffer can write the byte straight to that address. Checksums, event decoding, the transceiver and clock crossing belong to other blocks.

Top module: `seg_frame_parser`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pay_valid`, `pay_data` and `pay_addr` are zero. A reset in the middle of a frame abandons the frame, and no byte is emitted until a new start code arrives.
- R2: A frame starts only when the data byte (`rx_word[15:8]`) is 0x5C and the data K flag (`rx_isk[1]`) is 1. A 0x5C with the flag clear starts nothing.
- R3: Counting the start cycle as cycle 0, the byte in cycle 1 is discarded, cycle 2 carries the segment number and cycle 3 is discarded. The first payload byte is presented in cycle 4. Its valid strobe appears at the clock edge that samples it, and the strobe is seen during the following cycle.
- R4: Payload is sampled on every second cycle (cycles 4, 6, 8 and so on). Bytes and K flags in the cycles between are ignored. Each sampled byte gives exactly one single-cycle valid pulse.
- R5: The address of the payload byte with offset i (i starting at 0) is (segment × 16 + i) mod 2048.
- R6: In a payload sample cycle, the data byte 0x3C with its K flag set ends the frame. That byte is not emitted, and later non-start bytes produce nothing.
- R7: In a payload sample cycle, any other K-character, including 0x5C, aborts the frame to idle. No new frame starts from that byte.
- R8: The event byte (`rx_word[7:0]`) and its K flag (`rx_isk[0]`) never change the output.
- R9: After the 2047th payload byte of one frame, the parser returns to idle without waiting for an end code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 16 | [15:8] data-lane byte, [7:0] event-lane byte |
| rx_isk | input | 2 | [1] data-lane K flag, [0] event-lane K flag |
| pay_data | output | 8 | Payload byte |
| pay_addr | output | 11 | Payload byte address |
| pay_valid | output | 1 | One-clock strobe per payload byte |

## Verification
Each internal fault shows up at a different place on the outputs. If the phase state slips by one cycle, the first strobe is one cycle early or late, or a gap byte is emitted. The scoreboard stamps every expected byte with its cycle, so this shows up on the first byte of the frame. A wrong segment register or offset counter corrupts `pay_addr` from the first or second byte onward. A parser that misses an end, abort or reset keeps emitting bytes that the queue does not hold, and the quiet-window checks after each such event catch them within a few cycles.

// File: rtl/segp_pkg.sv
package segp_pkg;

   // phase of the data-lane frame walker
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR_SKIP,
      PH_SEG_NUM,
      PH_POST_SKIP,
      PH_TAKE,
      PH_GAP
   } segp_phase_t;

   // classification of the data-lane byte
   typedef enum logic [1:0] {
      KC_PLAIN,
      KC_START,
      KC_END,
      KC_OTHER
   } segp_kclass_t;

endpackage

// File: rtl/segp_kclass.sv
module segp_kclass #(
   parameter int          DATA_W     = 8,
   parameter logic [7:0]  START_CODE = 8'h5C,
   parameter logic [7:0]  END_CODE   = 8'h3C
) (
   input  logic [DATA_W-1:0]     lane_byte,
   input  logic                  lane_k,
   output segp_pkg::segp_kclass_t kind
);
   import segp_pkg::*;

   localparam logic [DATA_W-1:0] START_W = DATA_W'(START_CODE);
   localparam logic [DATA_W-1:0] END_W   = DATA_W'(END_CODE);

   always_comb begin
      if (!lane_k)                  kind = KC_PLAIN;
      else if (lane_byte == START_W) kind = KC_START;
      else if (lane_byte == END_W)   kind = KC_END;
      else                           kind = KC_OTHER;
   end

endmodule

// File: rtl/segp_fsm.sv
module segp_fsm #(
   parameter int OFS_W = 11
) (
   input  logic                   clk,
   input  logic                   rst,
   input  segp_pkg::segp_kclass_t kind,
   output logic                   seg_load,
   output logic                   take,
   output logic [OFS_W-1:0]       ofs
);
   import segp_pkg::*;

   localparam int MAX_BYTES = (1 << OFS_W) - 1;
   localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(MAX_BYTES - 1);

   segp_phase_t phase;

   assign seg_load = (phase == PH_SEG_NUM);
   assign take     = (phase == PH_TAKE) && (kind == KC_PLAIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         ofs   <= '0;
      end else begin
         case (phase)
            PH_IDLE:      if (kind == KC_START) phase <= PH_HDR_SKIP;
            PH_HDR_SKIP:  phase <= PH_SEG_NUM;
            PH_SEG_NUM:   phase <= PH_POST_SKIP;
            PH_POST_SKIP: begin
               phase <= PH_TAKE;
               ofs   <= '0;
            end
            PH_TAKE: begin
               if (kind == KC_END) begin
                  phase <= PH_IDLE;            // normal close
               end else if (kind != KC_PLAIN) begin
                  phase <= PH_IDLE;            // stray K: abandon
               end else begin
                  ofs   <= ofs + 1'b1;
                  phase <= (ofs == LAST_OFS) ? PH_IDLE : PH_GAP;
               end
            end
            PH_GAP:       phase <= PH_TAKE;
            default:      phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/segp_addr.sv
module segp_addr #(
   parameter int SEG_W     = 8,
   parameter int OFS_W     = 11,
   parameter int SEG_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             seg_load,
   input  logic [SEG_W-1:0] seg_in,
   input  logic [OFS_W-1:0] ofs,
   output logic [OFS_W-1:0] addr
);
   logic [SEG_W-1:0] seg_q;
   logic [OFS_W-1:0] base;

   always_ff @(posedge clk) begin
      if (rst)           seg_q <= '0;
      else if (seg_load) seg_q <= seg_in;
   end

   generate
      if (SEG_SHIFT == 0) begin : g_flat
         assign base = OFS_W'(seg_q);
      end else begin : g_shift
         assign base = OFS_W'({seg_q, {SEG_SHIFT{1'b0}}});
      end
   endgenerate

   assign addr = base + ofs;

endmodule

// File: rtl/seg_frame_parser.sv
module seg_frame_parser #(
   parameter int         DATA_W     = 8,
   parameter int         OFS_W      = 11,
   parameter int         SEG_SHIFT  = 4,
   parameter logic [7:0] START_CODE = 8'h5C,
   parameter logic [7:0] END_CODE   = 8'h3C
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [2*DATA_W-1:0] rx_word,
   input  logic [1:0]          rx_isk,
   output logic [DATA_W-1:0]   pay_data,
   output logic [OFS_W-1:0]    pay_addr,
   output logic                pay_valid
);
   import segp_pkg::*;

   generate
      if (DATA_W < 8)       begin : g_bad_dw  $error("DATA_W must be at least 8");    end
      if (OFS_W < 2)        begin : g_bad_ow  $error("OFS_W must be at least 2");     end
      if (SEG_SHIFT >= OFS_W) begin : g_bad_sh $error("SEG_SHIFT must be below OFS_W"); end
   endgenerate

   logic [DATA_W-1:0] lane_byte;
   logic              lane_k;
   segp_kclass_t      kind;
   logic              seg_load, take;
   logic [OFS_W-1:0]  ofs, addr_c;
   logic              unused_event_lane;

   assign lane_byte         = rx_word[2*DATA_W-1:DATA_W];
   assign lane_k            = rx_isk[1];
   assign unused_event_lane = ^{rx_word[DATA_W-1:0], rx_isk[0]};

   segp_kclass #(.DATA_W(DATA_W), .START_CODE(START_CODE), .END_CODE(END_CODE)) u_kc (
      .lane_byte (lane_byte),
      .lane_k    (lane_k),
      .kind      (kind)
   );

   segp_fsm #(.OFS_W(OFS_W)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .kind     (kind),
      .seg_load (seg_load),
      .take     (take),
      .ofs      (ofs)
   );

   segp_addr #(.SEG_W(DATA_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
      .clk      (clk),
      .rst      (rst),
      .seg_load (seg_load),
      .seg_in   (lane_byte),
      .ofs      (ofs),
      .addr     (addr_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pay_valid <= 1'b0;
         pay_data  <= '0;
         pay_addr  <= '0;
      end else begin
         pay_valid <= take;
         if (take) begin
            pay_data <= lane_byte;
            pay_addr <= addr_c;
         end
      end
   end

endmodule

// File: rtl/segp_checker.sv
module segp_checker #(
   parameter int DW = 8,
   parameter int AW = 11
) (
   input logic          clk,
   input logic          rst,
   input logic [DW-1:0] rx_data,
   input logic          rx_dk,
   input logic [DW-1:0] pay_data,
   input logic [AW-1:0] pay_addr,
   input logic          pay_valid
);

   // R1: reset leaves the strobe low in the next cycle
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> !pay_valid);

   // R3: an emitted byte is the data-lane byte of the previous cycle
   p_data_source_r3: assert property (@(posedge clk) disable iff (rst)
      pay_valid |-> pay_data == $past(rx_data));

   // R4: strobes never come back to back
   p_single_valid_r4: assert property (@(posedge clk) disable iff (rst)
      pay_valid |=> !pay_valid);

   // R5: strobes two cycles apart belong to one frame, addresses step by one
   p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
      (pay_valid && $past(pay_valid, 2)) |-> pay_addr == AW'($past(pay_addr, 2) + 1'b1));

   // R6 / R7: a K-character on the data lane is never emitted as payload
   p_k_never_payload_r6: assert property (@(posedge clk) disable iff (rst)
      rx_dk |=> !pay_valid);

endmodule

bind seg_frame_parser segp_checker #(.DW(DATA_W), .AW(OFS_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rx_data   (rx_word[2*DATA_W-1:DATA_W]),
   .rx_dk     (rx_isk[1]),
   .pay_data  (pay_data),
   .pay_addr  (pay_addr),
   .pay_valid (pay_valid)
);

// File: tb/sim_seg_frame_parser.sv
module sim_seg_frame_parser;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] rx_word = 16'h0000;
   logic [1:0]  rx_isk  = 2'b00;
   logic [7:0]  pay_data;
   logic [10:0] pay_addr;
   logic        pay_valid;

   always #4 clk = ~clk;   // 125 MHz

   seg_frame_parser u0 (
      .clk(clk), .rst(rst), .rx_word(rx_word), .rx_isk(rx_isk),
      .pay_data(pay_data), .pay_addr(pay_addr), .pay_valid(pay_valid)
   );

   typedef struct {
      logic [7:0]  d;
      logic [10:0] a;
      int          cyc;
      int          tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   int   unexp = 0;
   logic [7:0] ev_byte = 8'h00;
   logic       ev_k    = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic string rq(input int t);
      case (t)
         1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
         5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
         default: return "R9";
      endcase
   endfunction

   // one data-lane cycle, event lane taken from ev_byte / ev_k
   task automatic put_d(input logic [7:0] d, input logic dk);
      rx_word = {d, ev_byte};
      rx_isk  = {dk, ev_k};
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] d, input logic [10:0] a, input int tag);
      exp_t e;
      e.d = d; e.a = a; e.cyc = cyc + 1; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // header plus n payload bytes; optional K in gap cycles; optional close
   task automatic frame(input logic [7:0] seg, input int n, input int tag,
                        input bit gap_k, input bit close);
      put_d(8'h5C, 1'b1);
      put_d(8'hA5, 1'b0);
      put_d(seg,   1'b0);
      put_d(8'h77, 1'b0);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'(i * 7 + int'(seg) + 3);
         push(b, 11'((int'(seg) * 16 + i) % 2048), tag);
         put_d(b, 1'b0);
         if (gap_k) put_d(8'h3C, 1'b1);
         else       put_d(8'h11, 1'b0);
      end
      if (close) put_d(8'h3C, 1'b1);
   endtask

   // plain bytes that must produce nothing, then verify nothing came
   task automatic quiet(input int n, input int tag);
      int u0_cnt;
      u0_cnt = unexp;
      for (int i = 0; i < n; i++) put_d(8'(8'h40 + i), 1'b0);
      repeat (2) @(negedge clk);
      checks++;
      if (unexp != u0_cnt || exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s quiet window: actual unexpected=%0d pending=%0d expected 0 and 0",
                  rq(tag), unexp - u0_cnt, exp_q.size());
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && pay_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            unexp++;
            errors++;
            $display("FAIL R4 unexpected byte: actual d=%h a=%h expected no strobe",
                     pay_data, pay_addr);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (pay_data !== e.d || pay_addr !== e.a || cyc != e.cyc) begin
               errors++;
               $display("FAIL %s payload: actual d=%h a=%h cyc=%0d expected d=%h a=%h cyc=%0d",
                        rq(e.tag), pay_data, pay_addr, cyc, e.d, e.a, e.cyc);
            end
         end
      end
   end

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (pay_valid !== 1'b0 || pay_data !== 8'h00 || pay_addr !== 11'h000) begin
         errors++;
         $display("FAIL R1 reset outputs: actual v=%b d=%h a=%h expected 0 00 000",
                  pay_valid, pay_data, pay_addr);
      end
      rst = 1'b0;
      put_d(8'h00, 1'b0);

      // R3 R4 R5: basic frame, timing stamped per byte
      frame(8'h02, 5, 3, 1'b0, 1'b1);
      quiet(6, 6);   // R6: nothing after close

      // R2: unflagged start code and flagged event-lane start code start nothing
      ev_byte = 8'h5C; ev_k = 1'b1;
      put_d(8'h5C, 1'b0);
      quiet(8, 2);

      // R8: event lane busy with K codes during a frame
      frame(8'h10, 4, 8, 1'b0, 1'b1);
      quiet(4, 8);
      ev_byte = 8'h00; ev_k = 1'b0;

      // R4: K-characters in gap cycles are ignored
      frame(8'h21, 4, 4, 1'b1, 1'b1);
      quiet(4, 4);

      // R7: start code in a sample cycle aborts, header-like bytes follow
      frame(8'h05, 3, 7, 1'b0, 1'b0);
      put_d(8'h5C, 1'b1);
      quiet(10, 7);
      // R7: other K in a sample cycle aborts as well
      frame(8'h06, 2, 7, 1'b0, 1'b0);
      put_d(8'hBC, 1'b1);
      quiet(10, 7);

      // R5: segment 0xFF wraps the 11-bit address
      frame(8'hFF, 20, 5, 1'b0, 1'b1);
      quiet(3, 5);

      // R1: reset in the middle of a frame
      frame(8'h03, 2, 1, 1'b0, 1'b0);
      rst = 1'b1;
      put_d(8'h12, 1'b0);
      put_d(8'h13, 1'b0);
      rst = 1'b0;
      quiet(12, 1);

      // R9: full segment ends the frame on its own
      frame(8'h00, 2047, 9, 1'b0, 1'b0);
      quiet(12, 9);

      // parser still works after all that
      frame(8'h07, 3, 3, 1'b0, 1'b1);
      quiet(3, 3);

      summary();
      $finish;
   end

endmodule